// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns one character at a time into an asynchronous serial frame on a single line that rests high. A character arrives with a valid/ready handshake. The block then sends a low start bit, followed by 5 to 8 data bits with the least-significant bit first. An optional parity bit comes next, and the frame ends with one or two high stop bits. Each bit lasts exactly one period of an external bit-rate tick. The tick is a one-cycle pulse per bit period, produced by a baud generator outside this block.

A set of line-control inputs chooses the frame shape:

- data length
- parity on or off
- parity sense (odd or even)
- stick (constant) parity
- second stop bit
- break request

The block captures these fields together with the character when it accepts the character. A change made while a frame is in flight therefore affects only the next frame. When break is requested, the line is held low, but only after any character already accepted has been sent completely. While break is held, the block accepts no characters.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `chr_ready` is 1. With all control inputs at 0, a frame has 5 data bits, no parity bit and one stop bit.
- R2: `cfg_wlen` selects the number of data bits: 0→5, 1→6, 2→7, 3→8. The frame is one low start bit, then the data bits taken from `chr_data` bit 0 upward.
- R3: Once a character is accepted, the start bit begins at the first `bit_tick`. From then on `txd` changes only on a cycle after a `bit_tick`, so every bit lasts exactly one tick period.
- R4: With `cfg_par_en` at 0, no parity bit is sent, and `cfg_par_even` and `cfg_par_stick` have no effect on the frame.
- R5: With parity enabled and stick off, a parity bit follows the data bits. With `cfg_par_even` at 0, the total number of ones over the data and parity bits is odd. With `cfg_par_even` at 1, that total is even.
- R6: With parity enabled and `cfg_par_stick` at 1, the parity bit is the inverse of `cfg_par_even`.
- R7: Each frame ends with one high stop bit, or two when `cfg_two_stop` is 1. Each stop bit lasts one tick period. The block becomes idle at the tick that ends the last stop bit.
- R8: The control fields and the character are captured on acceptance. Changing the control fields mid-frame leaves the current frame unchanged.
- R9: With `cfg_brk` at 1, the line is driven low from the cycle after the block is idle, and stays low while `cfg_brk` stays 1. A frame in flight completes first. `chr_ready` stays 0 for as long as `cfg_brk` is 1.
- R10: When `cfg_brk` falls, the line returns high on the next cycle. A character offered during break is accepted only after the release, and its start bit waits for the next tick.
- R11: `chr_ready` is 1 only when the block is idle and `cfg_brk` is 0. `busy` is 1 from acceptance through the last stop bit, and during break. The line is high whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| chr_data | input | 8 | Character to send, bit 0 first |
| chr_valid | input | 1 | Character offered |
| chr_ready | output | 1 | Character can be accepted this cycle |
| cfg_wlen | input | 2 | Data length code: 0→5 … 3→8 bits |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_even | input | 1 | 1 = even total of ones, 0 = odd |
| cfg_par_stick | input | 1 | Parity bit fixed to the inverse of cfg_par_even |
| cfg_two_stop | input | 1 | Send two stop bits |
| cfg_brk | input | 1 | Hold the line low once idle |
| txd | output | 1 | Serial line, high when idle |
| busy | output | 1 | Frame or break in progress |

## Verification
On every cycle, the assertions check the handshake and line invariants:

- `chr_ready` never coexists with `busy` or a break request.
- The line is high when the block is not busy.
- The line holds still between ticks while a frame is in flight.
- A break seen while idle pulls the line low on the next cycle and keeps it low.

Only the bench scenarios can show the frame contents. These are the data length, bit order, parity value for each mode, stop-bit count, the snapshot of controls taken at acceptance, and the ordering of break after a frame. The bench compares the line and the flags on every cycle against a queue-based reference model across all lengths, parity modes, stop settings and tick rates.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_BREAK
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
  } line_cfg_t;

endpackage

// File: rtl/uart_tx_latch.sv
// Captures the character and frame controls on acceptance and
// precomputes the parity bit and the index of the last data bit.
module uart_tx_latch
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int MIN_BITS = DATA_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  line_cfg_t         cfg_in,
  output logic [DATA_W-1:0] data_q,
  output logic              par_en_q,
  output logic              two_stop_q,
  output logic              par_bit_q,
  output logic [IDX_W-1:0]  last_idx_q
);

  logic [IDX_W-1:0]  last_idx_d;
  logic [DATA_W-1:0] masked;
  logic              ones_odd;
  logic              par_d;

  assign last_idx_d = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_in.wlen);

  // keep only the bits that belong to the selected length
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data_in[i] & (IDX_W'(i) <= last_idx_d);
  end

  assign ones_odd = ^masked;

  always_comb begin
    if (cfg_in.par_stick) par_d = ~cfg_in.par_even;
    else if (cfg_in.par_even) par_d = ones_odd;
    else par_d = ~ones_odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      par_en_q   <= 1'b0;
      two_stop_q <= 1'b0;
      par_bit_q  <= 1'b0;
      last_idx_q <= IDX_W'(MIN_BITS - 1);
    end else if (load) begin
      data_q     <= data_in;
      par_en_q   <= cfg_in.par_en;
      two_stop_q <= cfg_in.two_stop;
      par_bit_q  <= par_d;
      last_idx_q <= last_idx_d;
    end
  end

endmodule

// File: rtl/uart_tx_fsm.sv
// Frame sequencer: walks start, data, parity, stop and break phases
// on bit ticks and drives the registered line.
module uart_tx_fsm
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              brk,
  input  logic              chr_valid,
  input  logic [DATA_W-1:0] data_q,
  input  logic              par_en_q,
  input  logic              two_stop_q,
  input  logic              par_bit_q,
  input  logic [IDX_W-1:0]  last_idx_q,
  output logic              accept,
  output logic              ready,
  output logic              busy,
  output logic              brk_on,
  output logic              txd
);

  tx_state_e        st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nx;

  assign ready  = (st_q == ST_IDLE) && !brk;
  assign accept = ready && chr_valid;
  assign busy   = (st_q != ST_IDLE);
  assign brk_on = (st_q == ST_BREAK);
  assign idx_nx = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      txd   <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (brk) begin
            st_q <= ST_BREAK;
            txd  <= 1'b0;
          end else if (chr_valid) begin
            st_q <= ST_ARM;
          end
        end
        ST_ARM: if (tick) begin
          st_q <= ST_START;
          txd  <= 1'b0;
        end
        ST_START: if (tick) begin
          st_q  <= ST_DATA;
          idx_q <= '0;
          txd   <= data_q[0];
        end
        ST_DATA: if (tick) begin
          if (idx_q == last_idx_q) begin
            if (par_en_q) begin
              st_q <= ST_PAR;
              txd  <= par_bit_q;
            end else begin
              st_q <= ST_STOP1;
              txd  <= 1'b1;
            end
          end else begin
            idx_q <= idx_nx;
            txd   <= data_q[idx_nx];
          end
        end
        ST_PAR: if (tick) begin
          st_q <= ST_STOP1;
          txd  <= 1'b1;
        end
        ST_STOP1: if (tick) begin
          st_q <= two_stop_q ? ST_STOP2 : ST_IDLE;
        end
        ST_STOP2: if (tick) begin
          st_q <= ST_IDLE;
        end
        ST_BREAK: if (!brk) begin
          st_q <= ST_IDLE;
          txd  <= 1'b1;
        end
        default: begin
          st_q <= ST_IDLE;
          txd  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_valid,
  output logic              chr_ready,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_two_stop,
  input  logic              cfg_brk,
  output logic              txd,
  output logic              busy
);

  line_cfg_t         cfg;
  logic              load;
  logic [DATA_W-1:0] data_q;
  logic              par_en_q;
  logic              two_stop_q;
  logic              par_bit_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic              brk_on;

  assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en, par_even: cfg_par_even,
                 par_stick: cfg_par_stick, two_stop: cfg_two_stop};

  uart_tx_latch #(.DATA_W(DATA_W)) i_latch (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .data_in    (chr_data),
    .cfg_in     (cfg),
    .data_q     (data_q),
    .par_en_q   (par_en_q),
    .two_stop_q (two_stop_q),
    .par_bit_q  (par_bit_q),
    .last_idx_q (last_idx_q)
  );

  uart_tx_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick       (bit_tick),
    .brk        (cfg_brk),
    .chr_valid  (chr_valid),
    .data_q     (data_q),
    .par_en_q   (par_en_q),
    .two_stop_q (two_stop_q),
    .par_bit_q  (par_bit_q),
    .last_idx_q (last_idx_q),
    .accept     (load),
    .ready      (chr_ready),
    .busy       (busy),
    .brk_on     (brk_on),
    .txd        (txd)
  );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic cfg_brk,
  input logic chr_ready,
  input logic txd,
  input logic busy,
  input logic in_break
);

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    chr_ready |-> (!busy && !cfg_brk));

  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  // R3
  tick_paced_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_tick && !in_break) |=> $stable(txd));

  // R9
  brk_engage_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_brk && !busy) |=> (busy && !txd));

  // R9
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    in_break |-> !txd);

  // R10
  brk_release_chk: assert property (@(posedge clk) disable iff (rst)
    (in_break && !cfg_brk) |=> (txd && !busy));

endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_tick  (bit_tick),
  .cfg_brk   (cfg_brk),
  .chr_ready (chr_ready),
  .txd       (txd),
  .busy      (busy),
  .in_break  (brk_on)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic [7:0] chr_data = '0;
  logic       chr_valid = 1'b0;
  logic       chr_ready;
  logic [1:0] cfg_wlen = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_stick = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_brk = 1'b0;
  logic       txd;
  logic       busy;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  int    tick_div = 5;
  int    tick_cnt = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .chr_data(chr_data),
    .chr_valid(chr_valid), .chr_ready(chr_ready), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_two_stop(cfg_two_stop),
    .cfg_brk(cfg_brk), .txd(txd), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: mode 0 idle, 1 frame, 2 break
  int m_mode = 0;
  bit m_txd = 1'b1;
  bit q[$];

  function automatic void build_frame();
    int n;
    int ones;
    bit par;
    n = 5 + int'(cfg_wlen);
    ones = 0;
    q.delete();
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      q.push_back(chr_data[i]);
      ones += int'(chr_data[i]);
    end
    if (cfg_par_en) begin
      if (cfg_par_stick) par = !cfg_par_even;
      else if (cfg_par_even) par = (ones % 2) == 1;
      else par = (ones % 2) == 0;
      q.push_back(par);
    end
    q.push_back(1'b1);
    if (cfg_two_stop) q.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0;
      m_txd  = 1'b1;
      q.delete();
    end else begin
      case (m_mode)
        0: if (cfg_brk) begin
             m_mode = 2;
             m_txd  = 1'b0;
           end else if (chr_valid) begin
             build_frame();
             m_mode = 1;
           end
        1: if (bit_tick) begin
             if (q.size() > 0) m_txd = q.pop_front();
             else m_mode = 0;
           end
        default: if (!cfg_brk) begin
             m_mode = 0;
             m_txd  = 1'b1;
           end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!rst) begin
      chk(txd == m_txd, cur_req, "txd", int'(txd), int'(m_txd));
      chk(busy == (m_mode != 0), "R11", "busy", int'(busy), int'(m_mode != 0));
      chk(chr_ready == (m_mode == 0 && !cfg_brk), "R11", "chr_ready",
          int'(chr_ready), int'(m_mode == 0 && !cfg_brk));
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // bit-rate tick
  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick_cnt = 0;
      bit_tick = 1'b1;
    end else begin
      tick_cnt++;
      bit_tick = 1'b0;
    end
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    chr_data  = d;
    chr_valid = 1'b1;
    forever begin
      if (chr_ready) begin
        @(negedge clk);
        chr_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(chr_ready == 1'b1, "R1", "ready after reset", int'(chr_ready), 1);
    cur_req = "R1";
    send(8'hB6);
    wait_idle();

    // R2 R5 R6 R7 R4: every length, parity mode and stop setting
    for (int w = 0; w < 4; w++) begin
      for (int pm = 0; pm < 5; pm++) begin
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          cfg_wlen     = 2'(w);
          cfg_two_stop = s[0];
          cfg_par_en   = (pm != 0);
          cfg_par_even = (pm == 2 || pm == 4);
          cfg_par_stick = (pm >= 3);
          if (pm == 0) cur_req = "R2 R4 R7";
          else if (pm < 3) cur_req = "R2 R5 R7";
          else cur_req = "R2 R6 R7";
          send(8'hA5 ^ 8'(w * 37 + pm * 11 + s));
          wait_idle();
        end
      end
    end

    // R4: parity sense and stick ignored when parity is off
    @(negedge clk);
    cur_req = "R4";
    cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_par_even = 1'b1; cfg_par_stick = 1'b1;
    cfg_two_stop = 1'b0;
    send(8'h7E);
    wait_idle();

    // R3: other tick rates, including a tick every cycle
    cur_req = "R3";
    tick_div = 3;
    send(8'h3C);
    wait_idle();
    tick_div = 1;
    send(8'hC3);
    wait_idle();
    tick_div = 7;
    send(8'h81);
    wait_idle();
    tick_div = 5;

    // R8: controls change mid-frame
    cur_req = "R8";
    @(negedge clk);
    cfg_wlen = 2'd1; cfg_par_en = 1'b1; cfg_par_even = 1'b0; cfg_par_stick = 1'b0;
    cfg_two_stop = 1'b1;
    send(8'h2D);
    repeat (12) @(negedge clk);
    cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    wait_idle();
    send(8'hF0);
    wait_idle();

    // R9: break requested during a frame waits for its end
    cur_req = "R9";
    send(8'h55);
    repeat (8) @(negedge clk);
    cfg_brk = 1'b1;
    chk(busy == 1'b1, "R9", "frame still in flight", int'(busy), 1);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(txd == 1'b0, "R9", "line during break", int'(txd), 0);
    chk(chr_ready == 1'b0, "R9", "ready during break", int'(chr_ready), 0);
    chr_data  = 8'h99;
    chr_valid = 1'b1;
    repeat (30) @(negedge clk);
    chk(txd == 1'b0, "R9", "offered char not sent in break", int'(txd), 0);

    // R10: release, then the held character goes out
    cur_req = "R10";
    cfg_brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R10", "line after release", int'(txd), 1);
    while (!chr_ready) @(negedge clk);
    @(negedge clk);
    chr_valid = 1'b0;
    wait_idle();

    // R9: break raised while idle engages next cycle
    cur_req = "R9";
    @(negedge clk);
    cfg_brk = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R9", "idle break engage", int'(txd), 0);
    repeat (10) @(negedge clk);
    cfg_brk = 1'b0;
    cur_req = "R10";
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule